// File: doc/BRIEF.md
# Biresidue Arithmetic Error Corrector

This block protects a 12-bit value with two check residues, one modulo 7 and one modulo 15. It finds and repairs a single arithmetic error, meaning that the value has drifted by exactly plus or minus a power of two. A producer uses the built-in encoder to form the two residues of a clean value and stores or sends them with it. A consumer presents the value with its two residues and a valid strobe. The corrector computes both residues of the received value again. It subtracts the stored residues from them, each modulo its own modulus, which gives a syndrome pair.

Each weight-1 error of the form +2^j or -2^j with j from 0 to 11 gives its own syndrome pair. The block looks the pair up in a table of 24 entries. When it finds a match it recovers the error's position and sign and undoes the error, modulo 2^12. A zero pair means the value is clean. Any other pair is reported as uncorrectable, and the received value is passed on unchanged. The verdict and the value are registered and appear one cycle after the strobe.

Top module: `biresidue_corrector`

## Requirements
- R1: While reset is asserted, and until the first strobe after it, out_valid, out_fixed and out_fail are 0 and out_value is 0.
- R2: The encoder is combinational. enc_res_a equals enc_value mod 7, always in 0..6, and enc_res_b equals enc_value mod 15, always in 0..14.
- R3: When the received value's residues match the stored ones, out_value equals in_value and both out_fixed and out_fail are 0.
- R4: When in_value = x + 2^j (0 <= j <= 11, no wrap) and the stored residues are those of x, out_value = x and out_fixed = 1. The mod-7 syndrome is 2^(j mod 3) and the mod-15 syndrome is 2^(j mod 4).
- R5: When in_value = x - 2^j (0 <= j <= 11, no wrap) and the stored residues are those of x, out_value = x and out_fixed = 1. The syndromes are 7 - 2^(j mod 3) and 15 - 2^(j mod 4).
- R6: A stored residue that is all ones (7 for the mod-7 residue, 15 for the mod-15 residue) is treated as 0.
- R7: A nonzero syndrome pair that is not one of the 24 weight-1 pairs sets out_fail = 1 and out_fixed = 0, and out_value equals in_value.
- R8: Results are registered. out_valid is in_valid delayed by one cycle, and out_value, out_fixed and out_fail change only in the cycle after a strobe. Otherwise they hold.
- R9: out_fixed and out_fail are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enc_value | input | 12 | Value to be encoded |
| enc_res_a | output | 3 | enc_value mod 7 |
| enc_res_b | output | 4 | enc_value mod 15 |
| in_valid | input | 1 | Strobe: in_value and the residues are to be checked |
| in_value | input | 12 | Received value |
| in_res_a | input | 3 | Stored mod-7 residue |
| in_res_b | input | 4 | Stored mod-15 residue |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_value | output | 12 | Corrected or passed-through value |
| out_fixed | output | 1 | A weight-1 error was found and removed |
| out_fail | output | 1 | Error detected that cannot be corrected |

## Verification
A faulty residue fold or subtractor makes clean words look corrupted, so out_fixed or out_fail rises in the cycle right after the strobe. A wrong locator entry moves one error position or sign, which shows as out_value off by a power of two for exactly that j and sign. For this reason every j is driven with both signs. A capture register that is not enabled properly shows at the next idle cycle, when out_value changes without a strobe.

// File: rtl/biresidue_pkg.sv
package biresidue_pkg;

  typedef enum logic [1:0] {
    VERD_CLEAN = 2'd0,
    VERD_FIXED = 2'd1,
    VERD_FAIL  = 2'd2
  } verdict_e;

endpackage

// File: rtl/residue_fold.sv
// Residue of a value modulo 2^W-1: sum the W-bit chunks, fold the carries
// end-around, and treat an all-ones result as zero.
module residue_fold #(
  parameter int unsigned IN_W = 12,
  parameter int unsigned W    = 3
) (
  input  logic [IN_W-1:0] value,
  output logic [W-1:0]    residue
);
  localparam int unsigned CHUNKS = (IN_W + W - 1) / W;
  localparam int unsigned PAD_W  = CHUNKS * W;
  localparam int unsigned ACC_W  = W + $clog2(CHUNKS + 1) + 1;

  logic [PAD_W-1:0] padded;
  logic [ACC_W-1:0] acc;

  always_comb begin
    padded = '0;
    padded[IN_W-1:0] = value;
    acc = '0;
    for (int c = 0; c < CHUNKS; c++) begin
      acc = acc + ACC_W'(padded[c*W +: W]);
    end
    for (int k = 0; k < ACC_W; k++) begin
      acc = ACC_W'(acc[W-1:0]) + (acc >> W);
    end
    residue = (acc[W-1:0] == {W{1'b1}}) ? '0 : acc[W-1:0];
  end
endmodule

// File: rtl/residue_diff.sv
// (a - b) mod 2^W-1 using one's-complement addition.
module residue_diff #(
  parameter int unsigned W = 3
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] diff
);
  logic [W:0]   sum;
  logic [W-1:0] folded;

  always_comb begin
    sum    = {1'b0, a} + {1'b0, ~b};
    folded = sum[W-1:0] + W'(sum[W]);
    diff   = (folded == {W{1'b1}}) ? '0 : folded;
  end
endmodule

// File: rtl/residue_encoder.sv
module residue_encoder #(
  parameter int unsigned A_BITS = 3,
  parameter int unsigned B_BITS = 4,
  localparam int unsigned DATA_W = A_BITS * B_BITS
) (
  input  logic [DATA_W-1:0] value,
  output logic [A_BITS-1:0] res_a,
  output logic [B_BITS-1:0] res_b
);
  residue_fold #(.IN_W(DATA_W), .W(A_BITS)) u_fold_a (.value(value), .residue(res_a));
  residue_fold #(.IN_W(DATA_W), .W(B_BITS)) u_fold_b (.value(value), .residue(res_b));
endmodule

// File: rtl/syndrome_locator.sv
// One comparator per error position and sign. For +2^j the syndromes are
// single ones at j mod A_BITS and j mod B_BITS; for -2^j they are the
// complements of those.
module syndrome_locator #(
  parameter int unsigned A_BITS = 3,
  parameter int unsigned B_BITS = 4,
  localparam int unsigned DATA_W = A_BITS * B_BITS
) (
  input  logic [A_BITS-1:0] syn_a,
  input  logic [B_BITS-1:0] syn_b,
  output logic [DATA_W-1:0] pos_hit,
  output logic [DATA_W-1:0] neg_hit
);
  for (genvar j = 0; j < DATA_W; j++) begin : g_pos
    localparam logic [A_BITS-1:0] PA = A_BITS'(1 << (j % A_BITS));
    localparam logic [B_BITS-1:0] PB = B_BITS'(1 << (j % B_BITS));
    localparam logic [A_BITS-1:0] NA = ~PA;
    localparam logic [B_BITS-1:0] NB = ~PB;
    assign pos_hit[j] = (syn_a == PA) && (syn_b == PB);
    assign neg_hit[j] = (syn_a == NA) && (syn_b == NB);
  end
endmodule

// File: rtl/biresidue_corrector.sv
module biresidue_corrector
  import biresidue_pkg::*;
#(
  parameter int unsigned A_BITS = 3,
  parameter int unsigned B_BITS = 4,
  localparam int unsigned DATA_W = A_BITS * B_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] enc_value,
  output logic [A_BITS-1:0] enc_res_a,
  output logic [B_BITS-1:0] enc_res_b,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_value,
  input  logic [A_BITS-1:0] in_res_a,
  input  logic [B_BITS-1:0] in_res_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_value,
  output logic              out_fixed,
  output logic              out_fail
);
  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  // Encoder for producers.
  residue_encoder #(.A_BITS(A_BITS), .B_BITS(B_BITS)) u_enc (
    .value(enc_value), .res_a(enc_res_a), .res_b(enc_res_b)
  );

  // Recompute the residues of the received value and form the syndromes.
  logic [A_BITS-1:0] rcv_a, syn_a;
  logic [B_BITS-1:0] rcv_b, syn_b;

  residue_encoder #(.A_BITS(A_BITS), .B_BITS(B_BITS)) u_recheck (
    .value(in_value), .res_a(rcv_a), .res_b(rcv_b)
  );
  residue_diff #(.W(A_BITS)) u_diff_a (.a(rcv_a), .b(in_res_a), .diff(syn_a));
  residue_diff #(.W(B_BITS)) u_diff_b (.a(rcv_b), .b(in_res_b), .diff(syn_b));

  logic [DATA_W-1:0] pos_hit, neg_hit;
  syndrome_locator #(.A_BITS(A_BITS), .B_BITS(B_BITS)) u_loc (
    .syn_a(syn_a), .syn_b(syn_b), .pos_hit(pos_hit), .neg_hit(neg_hit)
  );

  // Next-state logic.
  verdict_e          verdict;
  logic [DATA_W-1:0] nxt_value;
  logic              nxt_fixed, nxt_fail;

  always_comb begin
    if ((syn_a == '0) && (syn_b == '0)) begin
      verdict = VERD_CLEAN;
    end else if (|{pos_hit, neg_hit}) begin
      verdict = VERD_FIXED;
    end else begin
      verdict = VERD_FAIL;
    end
    nxt_value = (verdict == VERD_FIXED) ? (in_value - pos_hit + neg_hit) : in_value;
    nxt_fixed = (verdict == VERD_FIXED);
    nxt_fail  = (verdict == VERD_FAIL);
  end

  // Registers; the result is captured only on a strobe.
  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      out_valid <= 1'b0;
      out_value <= '0;
      out_fixed <= 1'b0;
      out_fail  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_value <= nxt_value;
        out_fixed <= nxt_fixed;
        out_fail  <= nxt_fail;
      end
    end
  end

  // Assertions
  a_r2_encoder_range: assert property (@(posedge clk) disable iff (!rst_sync)
    (enc_res_a != {A_BITS{1'b1}}) && (enc_res_b != {B_BITS{1'b1}}));

  a_r4_single_locate: assert property (@(posedge clk) disable iff (!rst_sync)
    $onehot0({pos_hit, neg_hit}));

  a_r3_clean_passthrough: assert property (@(posedge clk) disable iff (!rst_sync)
    $past(in_valid) && !out_fixed && !out_fail |-> out_value == $past(in_value));

  a_r7_fail_passthrough: assert property (@(posedge clk) disable iff (!rst_sync)
    $past(in_valid) && out_fail |-> out_value == $past(in_value));

  a_r8_valid_delay: assert property (@(posedge clk) disable iff (!rst_sync)
    out_valid == $past(in_valid));

  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_sync)
    !$past(in_valid) |-> $stable(out_value) && $stable(out_fixed) && $stable(out_fail));

  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_sync)
    !(out_fixed && out_fail));

endmodule

// File: tb/biresidue_corrector_tb.sv
`timescale 1ns/1ps
module biresidue_corrector_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] enc_value;
  logic [2:0]  enc_res_a;
  logic [3:0]  enc_res_b;
  logic        in_valid;
  logic [11:0] in_value;
  logic [2:0]  in_res_a;
  logic [3:0]  in_res_b;
  logic        out_valid;
  logic [11:0] out_value;
  logic        out_fixed;
  logic        out_fail;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  biresidue_corrector u_dut (
    .clk(clk), .rst_n(rst_n),
    .enc_value(enc_value), .enc_res_a(enc_res_a), .enc_res_b(enc_res_b),
    .in_valid(in_valid), .in_value(in_value), .in_res_a(in_res_a), .in_res_b(in_res_b),
    .out_valid(out_valid), .out_value(out_value), .out_fixed(out_fixed), .out_fail(out_fail)
  );

  // Vector table: {x[11:0], j[3:0], neg} with no wrap past 0 or 4095.
  localparam logic [16:0] VEC [12] = '{
    {12'd0,    4'd0,  1'b0}, {12'd1234, 4'd3,  1'b0}, {12'd3000, 4'd11, 1'b1},
    {12'd100,  4'd11, 1'b0}, {12'd4000, 4'd4,  1'b1}, {12'd4095, 4'd0,  1'b1},
    {12'd555,  4'd7,  1'b0}, {12'd777,  4'd9,  1'b1}, {12'd2500, 4'd5,  1'b0},
    {12'd1,    4'd0,  1'b1}, {12'd1333, 4'd10, 1'b0}, {12'd64,   4'd6,  1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic [11:0] v, input logic [2:0] ra, input logic [3:0] rb);
    @(negedge clk);
    in_valid = 1'b1;
    in_value = v;
    in_res_a = ra;
    in_res_b = rb;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [2:0] m7(input int x);
    return 3'(x % 7);
  endfunction
  function automatic logic [3:0] m15(input int x);
    return 4'(x % 15);
  endfunction

  // Inject error at j with sign, expect correction back to x.
  task automatic corr_case(input string req, input int x, input int j, input bit neg);
    int v;
    v = neg ? x - (1 << j) : x + (1 << j);
    apply(12'(v), m7(x), m15(x));
    chk({req, " value"}, int'(out_value), x);
    chk({req, " fixed"}, int'(out_fixed), 1);
    chk({req, " fail"},  int'(out_fail), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_value = '0; in_res_a = '0; in_res_b = '0;
    enc_value = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset out_valid", int'(out_valid), 0);
    chk("R1 reset out_value", int'(out_value), 0);
    chk("R1 reset flags", int'({out_fixed, out_fail}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release out_valid", int'(out_valid), 0);
    chk("R1 after release flags", int'({out_fixed, out_fail}), 0);

    // R2 encoder
    for (int i = 0; i < 4096; i += 97) begin
      enc_value = 12'(i); #1;
      chk("R2 enc mod7", int'(enc_res_a), i % 7);
      chk("R2 enc mod15", int'(enc_res_b), i % 15);
    end
    enc_value = 12'd4095; #1;
    chk("R2 enc mod7 max", int'(enc_res_a), 4095 % 7);
    chk("R2 enc mod15 max", int'(enc_res_b), 4095 % 15);

    // Table walk: R4 (positive) and R5 (negative)
    for (int k = 0; k < 12; k++) begin
      if (VEC[k][0]) corr_case("R5 table", int'(VEC[k][16:5]), int'(VEC[k][4:1]), 1'b1);
      else           corr_case("R4 table", int'(VEC[k][16:5]), int'(VEC[k][4:1]), 1'b0);
      chk("R8 out_valid after strobe", int'(out_valid), 1);
    end

    // Every position with both signs
    for (int j = 0; j < 12; j++) begin
      corr_case("R4 sweep", 100 + j * 53, j, 1'b0);
      corr_case("R5 sweep", 2048 + j * 37, j, 1'b1);
    end

    // R3 clean words
    apply(12'd2345, m7(2345), m15(2345));
    chk("R3 clean value", int'(out_value), 2345);
    chk("R3 clean flags", int'({out_fixed, out_fail}), 0);
    apply(12'd4095, m7(4095), m15(4095));
    chk("R3 clean max", int'(out_value), 4095);
    chk("R3 clean max flags", int'({out_fixed, out_fail}), 0);

    // R6 all-ones stored residues mean zero
    apply(12'd105, 3'd7, 4'd15);
    chk("R6 all-ones clean value", int'(out_value), 105);
    chk("R6 all-ones clean flags", int'({out_fixed, out_fail}), 0);
    apply(12'd218, 3'd7, 4'd15);
    chk("R6 all-ones corrected value", int'(out_value), 210);
    chk("R6 all-ones fixed", int'(out_fixed), 1);

    // R7 uncorrectable: +3 gives pair (3,3); a lone mod-7 syndrome gives (1,0)
    apply(12'd503, m7(500), m15(500));
    chk("R7 weight-2 fail", int'(out_fail), 1);
    chk("R7 weight-2 fixed", int'(out_fixed), 0);
    chk("R7 weight-2 value", int'(out_value), 503);
    apply(12'd500, 3'((500 % 7 + 6) % 7), m15(500));
    chk("R7 residue-only fail", int'(out_fail), 1);
    chk("R7 residue-only value", int'(out_value), 500);
    chk("R9 not both flags", int'(out_fixed & out_fail), 0);

    // R8 hold while idle
    @(negedge clk);
    in_value = 12'd77; in_res_a = 3'd1; in_res_b = 4'd2;
    @(negedge clk);
    chk("R8 idle out_valid", int'(out_valid), 0);
    chk("R8 idle hold value", int'(out_value), 500);
    chk("R8 idle hold fail", int'(out_fail), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule